// File: doc/BRIEF.md
# Saturating Halfword Multiply-Accumulate Unit

This execution unit sits in the integer datapath of a 32-bit processor and handles the signal-processing arithmetic class: signed halfword multiplies, multiply-accumulates into 32-bit or 64-bit totals, and signed saturating addition and subtraction, including variants that first double one operand with saturation. Each operation takes two or three 32-bit source operands and, for multiplies, two halfword select bits. A select bit of 0 picks bits [15:0] of its operand and a select bit of 1 picks bits [31:16]. The chosen halfword is sign-extended before use.

An operation is presented with `valid_i` high for one cycle. Its result appears on `result_o` with `valid_o` high after the next rising clock edge, and `result_o` then holds until the next valid operation. A sticky saturation flag records every clamp, and every signed overflow of a 32-bit accumulate. Software clears it through `sat_clr_i`.

Opcode encoding on `op_i`: 0 halfword MAC, 1 word-by-halfword MAC, 2 halfword long MAC, 3 halfword multiply, 4 word-by-halfword multiply, 5 saturating add, 6 saturating subtract, 7 doubling saturating add, 8 doubling saturating subtract. Codes 9 to 15 are undefined.

Top module: `sat_mac_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0, `result_o` is 0 and `sat_flag_o` is 0.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. `result_o` keeps its last value while no operation is accepted.
- R3: Opcode 3 returns the 32-bit signed product of halfword `sel_a_i` of `src_a_i` and halfword `sel_b_i` of `src_b_i`. Select value 0 means bits [15:0] and select value 1 means bits [31:16], each sign-extended.
- R4: Opcode 0 adds the halfword product to `acc_lo_i` modulo 2^32. It sets the flag when that addition overflows as a signed operation.
- R5: Opcodes 1 and 4 use bits [47:16] of the 48-bit signed product of `src_a_i` and the selected halfword of `src_b_i`, and ignore `sel_a_i`. Opcode 1 adds this value to `acc_lo_i` and sets the flag on signed overflow. Opcode 4 returns it unchanged.
- R6: Opcode 2 adds the sign-extended halfword product to the 64-bit value {`acc_hi_i`, `acc_lo_i`} modulo 2^64. The result fills all of `result_o` and never sets the flag.
- R7: Opcodes 5 and 6 return `src_a_i` + `src_b_i` and `src_a_i` - `src_b_i` respectively. A positive overflow clamps to 0x7FFFFFFF, a negative overflow clamps to 0x80000000, and any clamp sets the flag.
- R8: Opcodes 7 and 8 first form 2*`src_b_i` with saturation, then add that value to `src_a_i` or subtract it from `src_a_i` with a second saturation. Either clamp sets the flag.
- R9: The flag is sticky. `sat_clr_i` clears it at the next edge. When a flag-setting operation and a clear are in the same cycle, the flag ends up set.
- R10: Every opcode except 2 drives `result_o[63:32]` to 0. Opcodes 3 and 4 never set the flag.
- R11: An undefined opcode returns 0 with `valid_o` high and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Opcode |
| src_a_i | input | 32 | First source operand |
| src_b_i | input | 32 | Second source operand |
| acc_lo_i | input | 32 | Accumulator, low word |
| acc_hi_i | input | 32 | Accumulator, high word (long MAC only) |
| sel_a_i | input | 1 | Halfword select for src_a_i |
| sel_b_i | input | 1 | Halfword select for src_b_i |
| sat_clr_i | input | 1 | Clear the sticky saturation flag |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Registered result |
| sat_flag_o | output | 1 | Sticky saturation flag |

## Verification
Two events can update the sticky flag at the same edge: a clear request and an operation that saturates or whose accumulate overflows. The bench drives `sat_clr_i` together with a saturating add, and also together with a non-saturating multiply. The reference model gives the set priority over the clear, so the first case must leave the flag high and the second must leave it low. Back-to-back random operations mixed with sparse clears apply the same rule on every cycle, and the scoreboard compares the flag carried with each queued result.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;
  typedef enum logic [3:0] {
    OP_MAC_HH  = 4'd0,
    OP_MAC_WH  = 4'd1,
    OP_MACL_HH = 4'd2,
    OP_MUL_HH  = 4'd3,
    OP_MUL_WH  = 4'd4,
    OP_QADD    = 4'd5,
    OP_QSUB    = 4'd6,
    OP_QDADD   = 4'd7,
    OP_QDSUB   = 4'd8
  } mac_op_e;
endpackage

// File: rtl/sat_mac_halfsel.sv
module sat_mac_halfsel #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] ext_o
);
  logic [HALF_W-1:0] half;
  assign half  = sel_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
  assign ext_o = {{HALF_W{half[HALF_W-1]}}, half};
endmodule

// File: rtl/sat_mac_satadd.sv
module sat_mac_satadd #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         sat_o
);
  logic [W:0] ext;
  always_comb begin
    if (sub_i) ext = {a_i[W-1], a_i} - {b_i[W-1], b_i};
    else       ext = {a_i[W-1], a_i} + {b_i[W-1], b_i};
    sat_o = ext[W] ^ ext[W-1];
    if (!sat_o)      sum_o = ext[W-1:0];
    else if (ext[W]) sum_o = {1'b1, {(W-1){1'b0}}};
    else             sum_o = {1'b0, {(W-1){1'b1}}};
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit
  import sat_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int WIDE_W = DATA_W + HALF_W,
  localparam int LONG_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [3:0]        op_i,
  input  logic [DATA_W-1:0] src_a_i,
  input  logic [DATA_W-1:0] src_b_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              sat_clr_i,
  output logic              valid_o,
  output logic [LONG_W-1:0] result_o,
  output logic              sat_flag_o
);
  // halfword operand selection, one per source
  logic [DATA_W-1:0] src_w [2];
  logic              src_s [2];
  logic [DATA_W-1:0] half_x [2];
  assign src_w[0] = src_a_i;
  assign src_w[1] = src_b_i;
  assign src_s[0] = sel_a_i;
  assign src_s[1] = sel_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_hsel
    sat_mac_halfsel #(.DATA_W(DATA_W)) u_hsel (
      .word_i(src_w[g]),
      .sel_i (src_s[g]),
      .ext_o (half_x[g])
    );
  end

  // products
  logic [DATA_W-1:0] prod_hh;
  logic [WIDE_W-1:0] a_wide, b_wide, prod_wh;
  logic [DATA_W-1:0] prod_wh_top;
  assign prod_hh     = half_x[0] * half_x[1];
  assign a_wide      = {{HALF_W{src_a_i[DATA_W-1]}}, src_a_i};
  assign b_wide      = {{HALF_W{half_x[1][DATA_W-1]}}, half_x[1]};
  assign prod_wh     = a_wide * b_wide;
  assign prod_wh_top = prod_wh[WIDE_W-1:HALF_W];

  // 32-bit wrapping accumulate with overflow detect
  logic [DATA_W-1:0] mac_add, mac_sum;
  logic              mac_ovf;
  assign mac_add = (op_i == OP_MAC_WH) ? prod_wh_top : prod_hh;
  assign mac_sum = mac_add + acc_lo_i;
  assign mac_ovf = (mac_add[DATA_W-1] == acc_lo_i[DATA_W-1]) &&
                   (mac_sum[DATA_W-1] != mac_add[DATA_W-1]);

  // 64-bit wrapping accumulate
  logic [LONG_W-1:0] macl_sum;
  assign macl_sum = {acc_hi_i, acc_lo_i} + {{DATA_W{prod_hh[DATA_W-1]}}, prod_hh};

  // saturating add/sub, optional saturated doubling of src_b
  logic [DATA_W-1:0] dbl_val, q_opnd, q_val;
  logic              dbl_sat, q_sat, use_dbl, q_sub;
  assign use_dbl = (op_i == OP_QDADD) || (op_i == OP_QDSUB);
  assign q_sub   = (op_i == OP_QSUB)  || (op_i == OP_QDSUB);

  sat_mac_satadd #(.W(DATA_W)) u_dbl (
    .a_i(src_b_i), .b_i(src_b_i), .sub_i(1'b0), .sum_o(dbl_val), .sat_o(dbl_sat)
  );

  assign q_opnd = use_dbl ? dbl_val : src_b_i;

  sat_mac_satadd #(.W(DATA_W)) u_qadd (
    .a_i(src_a_i), .b_i(q_opnd), .sub_i(q_sub), .sum_o(q_val), .sat_o(q_sat)
  );

  // result select
  logic [LONG_W-1:0] res_d;
  logic              evt_d;
  always_comb begin
    res_d = '0;
    evt_d = 1'b0;
    case (op_i)
      OP_MAC_HH, OP_MAC_WH: begin
        res_d[DATA_W-1:0] = mac_sum;
        evt_d             = mac_ovf;
      end
      OP_MACL_HH: res_d = macl_sum;
      OP_MUL_HH:  res_d[DATA_W-1:0] = prod_hh;
      OP_MUL_WH:  res_d[DATA_W-1:0] = prod_wh_top;
      OP_QADD, OP_QSUB: begin
        res_d[DATA_W-1:0] = q_val;
        evt_d             = q_sat;
      end
      OP_QDADD, OP_QDSUB: begin
        res_d[DATA_W-1:0] = q_val;
        evt_d             = q_sat | dbl_sat;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      result_o   <= '0;
      sat_flag_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) result_o <= res_d;
      // set has priority over clear
      if (valid_i && evt_d) sat_flag_o <= 1'b1;
      else if (sat_clr_i)   sat_flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_mac_chk.sv
module sat_mac_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [3:0]  op_i,
  input logic        sat_clr_i,
  input logic        valid_o,
  input logic [63:0] result_o,
  input logic        sat_flag_o
);
  assert_valid_follows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  assert_result_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o));
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_flag_o && !sat_clr_i) |=> sat_flag_o);
  assert_flag_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_clr_i && !valid_i) |=> !sat_flag_o);
  assert_flag_rise_needs_op_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sat_flag_o) |-> $past(valid_i));
  assert_upper_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i != 4'd2) |=> (result_o[63:32] == 32'd0));
  assert_mul_no_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 4'd3 || op_i == 4'd4 || op_i == 4'd2) && !sat_flag_o)
      |=> !sat_flag_o);
  assert_undef_no_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd8 && !sat_flag_o) |=> !sat_flag_o);
endmodule

bind sat_mac_unit sat_mac_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .sat_clr_i (sat_clr_i),
  .valid_o   (valid_o),
  .result_o  (result_o),
  .sat_flag_o(sat_flag_o)
);

// File: tb/sat_mac_unit_bench.sv
`timescale 1ns/1ps
module sat_mac_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] src_a_i = '0, src_b_i = '0, acc_lo_i = '0, acc_hi_i = '0;
  logic        sel_a_i = 1'b0, sel_b_i = 1'b0, sat_clr_i = 1'b0;
  logic        valid_o;
  logic [63:0] result_o;
  logic        sat_flag_o;

  always #2.5 clk_i = ~clk_i;

  sat_mac_unit u_sat_mac_unit (.*);

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  logic [63:0] q_res [$];
  logic        q_flg [$];
  string       q_tag [$];
  logic        exp_flag = 1'b0;
  logic [63:0] last_res = '0;

  function automatic longint sx32(logic [31:0] v);
    return longint'(signed'(v));
  endfunction
  function automatic longint sx16(logic [15:0] v);
    return longint'(signed'(v));
  endfunction
  function automatic void sat32(input longint v, output logic [31:0] r, output bit s);
    s = 1'b1;
    if (v > 64'sd2147483647)       r = 32'h7FFF_FFFF;
    else if (v < -64'sd2147483648) r = 32'h8000_0000;
    else begin r = v[31:0]; s = 1'b0; end
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] lo, input logic [31:0] hi,
                       input logic sa, input logic sb, input logic clr, input string tag);
    longint ha, hb, p, w, s;
    logic [63:0] r;
    logic [31:0] d, q;
    bit ev, s1, s2;
    ha = sx16(sa ? a[31:16] : a[15:0]);
    hb = sx16(sb ? b[31:16] : b[15:0]);
    p  = ha * hb;
    w  = (sx32(a) * hb) >>> 16;
    r  = '0;
    ev = 1'b0;
    case (op)
      4'd0: begin s = p + sx32(lo); r[31:0] = s[31:0];
              ev = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd1: begin s = w + sx32(lo); r[31:0] = s[31:0];
              ev = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd2: r = {hi, lo} + p;
      4'd3: r[31:0] = p[31:0];
      4'd4: r[31:0] = w[31:0];
      4'd5: begin sat32(sx32(a) + sx32(b), q, ev); r[31:0] = q; end
      4'd6: begin sat32(sx32(a) - sx32(b), q, ev); r[31:0] = q; end
      4'd7: begin sat32(2 * sx32(b), d, s1); sat32(sx32(a) + sx32(d), q, s2);
              r[31:0] = q; ev = s1 | s2; end
      4'd8: begin sat32(2 * sx32(b), d, s1); sat32(sx32(a) - sx32(d), q, s2);
              r[31:0] = q; ev = s1 | s2; end
      default: r = '0;
    endcase
    exp_flag = ev ? 1'b1 : (clr ? 1'b0 : exp_flag);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; src_a_i = a; src_b_i = b; acc_lo_i = lo; acc_hi_i = hi;
    sel_a_i = sa; sel_b_i = sb; sat_clr_i = clr;
    q_res.push_back(r); q_flg.push_back(exp_flag); q_tag.push_back(tag);
    last_res = r;
  endtask

  task automatic idle(input int n, input logic clr);
    @(negedge clk_i);
    valid_i = 1'b0; sat_clr_i = clr;
    if (clr) exp_flag = 1'b0;
    repeat (n - 1) begin @(negedge clk_i); sat_clr_i = 1'b0; end
    @(negedge clk_i); sat_clr_i = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q_res.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R2: unexpected valid_o, actual 1 expected 0");
      end else begin
        string t;
        logic [63:0] er;
        logic        ef;
        er = q_res.pop_front(); ef = q_flg.pop_front(); t = q_tag.pop_front();
        check(result_o, er, {t, " result"});
        check({63'd0, sat_flag_o}, {63'd0, ef}, {t, " flag"});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({valid_o, sat_flag_o}, 2'b00, "R1 reset valid/flag");
    check(result_o, 64'd0, "R1 reset result");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 halfword selection
    apply(4'd3, 32'h8000_7FFF, 32'hFFFE_0003, 0, 0, 0, 0, 0, "R3 sel00");
    apply(4'd3, 32'h8000_7FFF, 32'hFFFE_0003, 0, 0, 1, 0, 0, "R3 sel10");
    apply(4'd3, 32'h8000_7FFF, 32'hFFFE_0003, 0, 0, 0, 1, 0, "R3 sel01");
    apply(4'd3, 32'h8000_7FFF, 32'hFFFE_0003, 0, 0, 1, 1, 0, "R3 sel11");
    apply(4'd3, 32'h0000_8000, 32'h8000_0000, 0, 0, 0, 1, 0, "R10 mul max no flag");
    // R4 mac with and without overflow
    apply(4'd0, 32'h0000_0010, 32'h0000_FFF0, 32'h0000_0100, 0, 0, 0, 0, "R4 mac plain");
    apply(4'd0, 32'h7FFF_0000, 32'h0000_7FFF, 32'h7FFF_FFFF, 0, 1, 0, 0, "R4 mac overflow");
    idle(2, 1'b1);
    check({63'd0, sat_flag_o}, 64'd0, "R9 clear alone");
    // R5 word-by-halfword
    apply(4'd4, 32'h1234_5678, 32'h8000_0003, 0, 0, 1, 1, 0, "R5 mulwh top sel");
    apply(4'd4, 32'h1234_5678, 32'h8000_0003, 0, 0, 0, 0, 0, "R5 mulwh sel_a ignored");
    apply(4'd1, 32'h8000_0000, 32'h0000_8000, 32'h8000_0000, 0, 0, 0, 0, "R5 macwh no ovf");
    apply(4'd1, 32'h7FFF_FFFF, 32'h0000_7FFF, 32'h7FFF_0000, 0, 0, 0, 0, "R5 macwh ovf");
    idle(1, 1'b1);
    // R6 long mac wrap
    apply(4'd2, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, "R6 wrap");
    apply(4'd2, 32'h0000_8000, 32'h0000_7FFF, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, "R6 neg prod");
    // R7 saturating add/sub
    apply(4'd5, 32'h7FFF_FFF0, 32'h0000_0100, 0, 0, 0, 0, 0, "R7 add pos clamp");
    apply(4'd5, 32'h8000_0010, 32'hFFFF_FF00, 0, 0, 0, 0, 1, "R7 add neg clamp");
    apply(4'd6, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, 0, 0, "R7 sub clamp");
    apply(4'd6, 32'h0000_0005, 32'h0000_0009, 0, 0, 0, 0, 0, "R7 sub plain");
    idle(1, 1'b1);
    // R8 doubling variants
    apply(4'd7, 32'h0000_0001, 32'h4000_0000, 0, 0, 0, 0, 0, "R8 dbl clamp");
    idle(1, 1'b1);
    apply(4'd7, 32'h7FFF_0000, 32'h0010_0000, 0, 0, 0, 0, 0, "R8 second clamp");
    idle(1, 1'b1);
    apply(4'd8, 32'hC000_0000, 32'h2000_0000, 0, 0, 0, 0, 0, "R8 sub exact min");
    apply(4'd8, 32'h0000_0000, 32'hA000_0000, 0, 0, 0, 0, 0, "R8 sub dbl neg clamp");
    // R9 clear and set in the same cycle
    apply(4'd5, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 1, "R9 set beats clear");
    apply(4'd3, 32'h0000_0002, 32'h0000_0003, 0, 0, 0, 0, 1, "R9 clear with mul");
    // R11 undefined opcode
    apply(4'd5, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, 0, 0, "R11 setup flag");
    apply(4'hF, 32'h1111_1111, 32'h2222_2222, 32'h3, 32'h4, 1, 1, 0, "R11 undefined");
    idle(3, 1'b0);
    check(result_o, last_res, "R2 hold when idle");
    check({63'd0, valid_o}, 64'd0, "R2 valid low when idle");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) ra = {ra[31], {31{~ra[31]}}};
      apply(4'($urandom_range(0, 9)), ra, rb, $urandom, $urandom,
            1'($urandom), 1'($urandom), 1'($urandom_range(0, 7) == 0), "R4-mix random");
    end
    idle(3, 1'b0);
    if (q_res.size() != 0) begin
      n_vec++; n_bad++;
      $display("FAIL R2: actual %0d results pending expected 0", q_res.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule